// File: doc/BRIEF.md
# Clock Loss Monitor Reset Generator

This block watches the system clock against a separate, free-running reference clock. When monitoring is on and the system clock stops making progress for too long, the block pulls an active-low, open-drain style reset line low and raises a sticky failure flag. The flag is shared with other watchdog sources and survives ordinary chip resets.

In the system clock domain a small counter divides the system clock down to a heartbeat signal. The reference domain synchronizes the heartbeat and measures the gap between its transitions in reference ticks. A gap of `WINDOW_TICKS` ticks counts as a failure. The line is then driven low for exactly `PULSE_CYC` reference cycles. If the gap grows on to `ABSENT_TICKS`, the clock is treated as absent and the line is held low until heartbeat transitions are seen again. A slow clock therefore gives one short pulse. An absent clock gives that pulse first and then a hold that ends when the clock recovers.

Software uses a two-entry register port in the system clock domain. Address 0 holds the enable bit and address 1 holds the failure flag. The flag clears only through a status read followed by a clear write, or through power-on reset.

Top module: `clk_loss_monitor`

## Requirements
- R1: Bit 0 at address 0 is the monitor enable and can be written at any time. A read returns its value on `reg_rdata` bit 0 one clock after the read strobe, with the other bits zero. While the bit is 0, `rst_drive_n` stays 1 whatever the system clock does.
- R2: The enable bit is cleared by `rst`, by `por`, and by `rst_pin_n` being sensed low. After any of these, a read of address 0 returns 0.
- R3: While enabled, a system clock that keeps running, with heartbeat transitions spaced well under `WINDOW_TICKS`, never drives `rst_drive_n` low.
- R4: After the system clock stops with the monitor on, `rst_drive_n` goes low about `WINDOW_TICKS` reference cycles after the last heartbeat transition that was seen. The allowance is a few cycles for synchronization.
- R5: If heartbeat transitions return before `ABSENT_TICKS`, the line is low for exactly `PULSE_CYC` consecutive reference cycles (4 by default) and then returns to 1.
- R6: If the gap reaches `ABSENT_TICKS`, `rst_drive_n` goes low again and stays low until heartbeat transitions return. It is then released within a few reference cycles.
- R7: Each detected failure sets `fail_flag`. A read of address 1 returns it on bit 0.
- R8: Writing 1 to bit 0 of address 1 clears the flag only if the last status read returned 1. A clear write that has no such read before it leaves `fail_flag` at 1.
- R9: `rst` and `rst_pin_n` low leave `fail_flag` unchanged. Only `por` or the read-then-clear sequence clears it.
- R10: After reset, `rst_drive_n` is 1, `fail_flag` is 0 and `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (monitored) |
| rst | input | 1 | Synchronous active-high chip reset, system domain |
| por | input | 1 | Synchronous active-high power-on reset, system domain |
| ref_clk | input | 1 | Free-running reference clock |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = enable, 1 = failure status |
| reg_wdata | input | DATA_W | Write data, bit 0 used |
| reg_rdata | output | DATA_W | Registered read data |
| fail_flag | output | 1 | Sticky clock failure flag |
| rst_drive_n | output | 1 | Active-low reset pull-down request (open-drain model) |
| rst_pin_n | input | 1 | Sensed level of the reset line |

## Verification
The properties assume that the two resets are asserted together at power-up. They also assume that register accesses happen only while the system clock runs, and that `rst_pin_n` stays low for several system cycles when it is asserted. The slow-versus-absent timing relies on the heartbeat half period, 2^(HB_DIV_W-1) system cycles, lasting more than two reference periods. It also relies on `ABSENT_TICKS` exceeding `WINDOW_TICKS + PULSE_CYC` with room for synchronization. The stimulus issues register operations only while the system clock is on. It chooses clock periods that meet the heartbeat condition and picks outage lengths that sit well clear of both thresholds, so every expected edge falls inside a known range of reference cycles.

// File: rtl/cm_pkg.sv
package cm_pkg;
  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_STAT = 1'b1
  } cm_reg_e;

  localparam int EN_BIT    = 0;
  localparam int FLAG_BIT  = 0;
  localparam int CLEAR_BIT = 0;
endpackage

// File: rtl/cm_sync.sv
module cm_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cm_gap_timer.sv
module cm_gap_timer #(
  parameter int WINDOW_TICKS = 50,
  parameter int ABSENT_TICKS = 200,
  parameter int PULSE_CYC    = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic ref_clk,
  input  logic ref_rst,
  input  logic hb_async,
  input  logic en_async,
  output logic drv_low,
  output logic fail_tgl,
  output logic en_ref
);
  localparam int GAP_W   = $clog2(ABSENT_TICKS + 1);
  localparam int PULSE_W = $clog2(PULSE_CYC + 1);
  localparam logic [GAP_W-1:0]   WIN_LAST = GAP_W'(WINDOW_TICKS - 1);
  localparam logic [GAP_W-1:0]   ABS_CAP  = GAP_W'(ABSENT_TICKS);
  localparam logic [PULSE_W-1:0] PULSE_LD = PULSE_W'(PULSE_CYC);

  logic [1:0]         sync_q;
  logic               hb_s, en_s, hb_d, edge_seen;
  logic [GAP_W-1:0]   gap_q, gap_nxt;
  logic [PULSE_W-1:0] pulse_q, pulse_nxt;
  logic               trip, absent_nxt;

  cm_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync (
    .clk (ref_clk),
    .rst (ref_rst),
    .d   ({en_async, hb_async}),
    .q   (sync_q)
  );

  assign hb_s      = sync_q[0];
  assign en_s      = sync_q[1];
  assign edge_seen = hb_s ^ hb_d;

  always_comb begin
    if (!en_s || edge_seen)  gap_nxt = '0;
    else if (gap_q != ABS_CAP) gap_nxt = gap_q + GAP_W'(1);
    else                     gap_nxt = gap_q;
  end

  assign trip = en_s && !edge_seen && (gap_q == WIN_LAST);

  always_comb begin
    if (trip)              pulse_nxt = PULSE_LD;
    else if (pulse_q != '0) pulse_nxt = pulse_q - PULSE_W'(1);
    else                   pulse_nxt = '0;
  end

  assign absent_nxt = en_s && (gap_nxt == ABS_CAP);

  always_ff @(posedge ref_clk) begin
    if (ref_rst) begin
      hb_d     <= 1'b0;
      gap_q    <= '0;
      pulse_q  <= '0;
      drv_low  <= 1'b0;
      fail_tgl <= 1'b0;
    end else begin
      hb_d     <= hb_s;
      gap_q    <= gap_nxt;
      pulse_q  <= pulse_nxt;
      drv_low  <= (pulse_nxt != '0) || absent_nxt;
      fail_tgl <= fail_tgl ^ trip;
    end
  end

  assign en_ref = en_s;
endmodule

// File: rtl/cm_sys_regs.sv
module cm_sys_regs
  import cm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HB_DIV_W    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              fail_tgl_async,
  input  logic              pin_n_async,
  output logic              ctrl_en,
  output logic              fail_flag,
  output logic              heartbeat
);
  logic [1:0]          sync_q;
  logic                pin_s, tgl_s, tgl_prev, set_evt;
  logic                rst_any, clr_evt, armed;
  logic [HB_DIV_W-1:0] hb_cnt;
  cm_reg_e             sel;
  logic                unused_wdata;

  cm_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk (clk),
    .rst (por),
    .d   ({pin_n_async, fail_tgl_async}),
    .q   (sync_q)
  );

  assign pin_s        = sync_q[1];
  assign tgl_s        = sync_q[0];
  assign set_evt      = tgl_s ^ tgl_prev;
  assign rst_any      = rst || por || !pin_s;
  assign sel          = cm_reg_e'(reg_addr);
  assign clr_evt      = reg_wr && (sel == REG_STAT) && reg_wdata[CLEAR_BIT] && armed;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst || por) hb_cnt <= '0;
    else            hb_cnt <= hb_cnt + HB_DIV_W'(1);
  end
  assign heartbeat = hb_cnt[HB_DIV_W-1];

  always_ff @(posedge clk) begin
    if (por) tgl_prev <= 1'b0;
    else     tgl_prev <= tgl_s;
  end

  always_ff @(posedge clk) begin
    if (rst_any)                           ctrl_en <= 1'b0;
    else if (reg_wr && (sel == REG_CTRL))  ctrl_en <= reg_wdata[EN_BIT];
  end

  always_ff @(posedge clk) begin
    if (por)          fail_flag <= 1'b0;
    else if (set_evt) fail_flag <= 1'b1;
    else if (clr_evt) fail_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst_any)                                     armed <= 1'b0;
    else if (set_evt || clr_evt)                     armed <= 1'b0;
    else if (reg_rd && (sel == REG_STAT) && fail_flag) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_any) reg_rdata <= '0;
    else if (reg_rd) begin
      reg_rdata <= '0;
      if (sel == REG_STAT) reg_rdata[FLAG_BIT] <= fail_flag;
      else                 reg_rdata[EN_BIT]   <= ctrl_en;
    end
  end
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor #(
  parameter int DATA_W       = 8,
  parameter int WINDOW_TICKS = 50,
  parameter int ABSENT_TICKS = 200,
  parameter int PULSE_CYC    = 4,
  parameter int HB_DIV_W     = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              ref_clk,
  input  logic              ref_rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              fail_flag,
  output logic              rst_drive_n,
  input  logic              rst_pin_n
);
  logic ctrl_en, heartbeat, fail_tgl, drv_low, mon_en_ref;

  cm_sys_regs #(
    .DATA_W      (DATA_W),
    .HB_DIV_W    (HB_DIV_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_regs (
    .clk            (clk),
    .rst            (rst),
    .por            (por),
    .reg_wr         (reg_wr),
    .reg_rd         (reg_rd),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .fail_tgl_async (fail_tgl),
    .pin_n_async    (rst_pin_n),
    .ctrl_en        (ctrl_en),
    .fail_flag      (fail_flag),
    .heartbeat      (heartbeat)
  );

  cm_gap_timer #(
    .WINDOW_TICKS (WINDOW_TICKS),
    .ABSENT_TICKS (ABSENT_TICKS),
    .PULSE_CYC    (PULSE_CYC),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_gap (
    .ref_clk  (ref_clk),
    .ref_rst  (ref_rst),
    .hb_async (heartbeat),
    .en_async (ctrl_en),
    .drv_low  (drv_low),
    .fail_tgl (fail_tgl),
    .en_ref   (mon_en_ref)
  );

  assign rst_drive_n = ~drv_low;
endmodule

// File: rtl/cm_checker.sv
module cm_checker #(
  parameter int DATA_W    = 8,
  parameter int PULSE_CYC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              por,
  input logic              ref_clk,
  input logic              ref_rst,
  input logic              reg_wr,
  input logic              reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              fail_flag,
  input logic              rst_drive_n,
  input logic              ctrl_en,
  input logic              mon_en_ref
);
  logic [7:0] low_run;

  always_ff @(posedge ref_clk) begin
    if (ref_rst)            low_run <= '0;
    else if (rst_drive_n)   low_run <= '0;
    else if (low_run != 8'hFF) low_run <= low_run + 8'd1;
  end

  // R5: once pulled low, the line stays low for at least the pulse length
  a_r5_pulse_min: assert property (@(posedge ref_clk) disable iff (ref_rst)
    $rose(rst_drive_n) |-> (low_run >= 8'(PULSE_CYC)));

  // R1: a new pull-down starts only while monitoring was enabled
  a_r1_no_drive_disabled: assert property (@(posedge ref_clk) disable iff (ref_rst)
    $fell(rst_drive_n) |-> $past(mon_en_ref));

  // R9: the flag drops only after a clear write
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (por)
    $fell(fail_flag) |-> $past(reg_wr && reg_addr && reg_wdata[0]));

  // R2: a chip reset leaves the enable bit cleared
  a_r2_reset_clears_en: assert property (@(posedge clk) disable iff (por)
    $past(rst) |-> !ctrl_en);
endmodule

bind clk_loss_monitor cm_checker #(.DATA_W(DATA_W), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .por         (por),
  .ref_clk     (ref_clk),
  .ref_rst     (ref_rst),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .fail_flag   (fail_flag),
  .rst_drive_n (rst_drive_n),
  .ctrl_en     (ctrl_en),
  .mon_en_ref  (mon_en_ref)
);

// File: tb/sim_clk_loss_monitor.sv
module sim_clk_loss_monitor;
  localparam int DW  = 8;
  localparam int WIN = 20;
  localparam int ABS = 48;
  localparam int PUL = 4;
  localparam int HBW = 4;

  logic clk = 1'b0, ref_clk = 1'b0;
  logic rst, por, ref_rst, reg_wr, reg_rd, reg_addr, rst_pin_n;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic fail_flag, rst_drive_n;

  bit    sys_run = 1'b1;
  bit    bg_high = 1'b0;
  string bg_req  = "R3";
  bit    done    = 1'b0;
  int    checks  = 0;
  int    failures = 0;
  bit    tr [1:160];
  int    run_s[$];
  int    run_l[$];

  initial forever begin
    #4;
    if (sys_run) clk = ~clk;
    else         clk = 1'b0;
  end
  initial forever #12 ref_clk = ~ref_clk;

  clk_loss_monitor #(
    .DATA_W(DW), .WINDOW_TICKS(WIN), .ABSENT_TICKS(ABS),
    .PULSE_CYC(PUL), .HB_DIV_W(HBW), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .rst(rst), .por(por), .ref_clk(ref_clk), .ref_rst(ref_rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fail_flag(fail_flag), .rst_drive_n(rst_drive_n), .rst_pin_n(rst_pin_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the expected idle level
  always @(negedge ref_clk) begin
    if (bg_high && !ref_rst) begin
      checks++;
      if (rst_drive_n !== 1'b1) begin
        failures++;
        $display("FAIL %s per-cycle rst_drive_n actual=%0d expected=1", bg_req, rst_drive_n);
      end
    end
  end

  task automatic reg_write(input logic a, input logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic a, output int d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = int'(reg_rdata);
  endtask

  task automatic outage(input int stop_at, input int total);
    int st;
    @(negedge ref_clk);
    sys_run = 1'b0;
    for (int i = 1; i <= total; i++) begin
      @(negedge ref_clk);
      tr[i] = rst_drive_n;
      if (i == stop_at) sys_run = 1'b1;
    end
    run_s.delete(); run_l.delete();
    st = 0;
    for (int i = 1; i <= total; i++) begin
      if (!tr[i] && st == 0) st = i;
      if (tr[i] && st != 0) begin run_s.push_back(st); run_l.push_back(i - st); st = 0; end
    end
    if (st != 0) begin run_s.push_back(st); run_l.push_back(total + 1 - st); end
  endtask

  initial begin
    int v, e0;
    rst = 1; por = 1; ref_rst = 1; rst_pin_n = 1;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = '0;
    repeat (6) @(negedge ref_clk);
    rst = 0; por = 0; ref_rst = 0;
    repeat (4) @(negedge ref_clk);

    // reset state
    check(rst_drive_n === 1'b1, "R10 rst_drive_n after reset", int'(rst_drive_n), 1);
    check(fail_flag === 1'b0, "R10 fail_flag after reset", int'(fail_flag), 0);
    check(reg_rdata === '0, "R10 reg_rdata after reset", int'(reg_rdata), 0);
    reg_read(1'b0, v); check(v == 0, "R2 enable reads 0 after reset", v, 0);

    // enable bit write and readback
    reg_write(1'b0, 8'h01); reg_read(1'b0, v); check(v == 1, "R1 enable readback 1", v, 1);
    reg_write(1'b0, 8'h00); reg_read(1'b0, v); check(v == 0, "R1 enable readback 0", v, 0);

    // disabled: long outage must not pull the line
    repeat (4) @(negedge ref_clk);
    bg_req = "R1"; bg_high = 1;
    outage(70, 80);
    repeat (10) @(negedge clk);
    check(fail_flag === 1'b0, "R1 no flag while disabled", int'(fail_flag), 0);

    // enabled, clock running
    reg_write(1'b0, 8'h01);
    bg_req = "R3";
    repeat (150) @(negedge ref_clk);
    bg_high = 0;

    // slow clock: short outage gives one pulse
    outage(30, 60);
    check(run_s.size() == 1, "R5 single low run for slow clock", run_s.size(), 1);
    v = run_s.size() > 0 ? run_s[0] : -1;
    check(v >= WIN - 3 && v <= WIN + 5, "R4 trip delay after stop", v, WIN + 2);
    v = run_l.size() > 0 ? run_l[0] : -1;
    check(v == PUL, "R5 pulse length in reference cycles", v, PUL);
    bg_high = 1;
    repeat (20) @(negedge clk);
    check(fail_flag === 1'b1, "R7 flag set by slow clock", int'(fail_flag), 1);

    // clear without prior read is ignored, then read-then-clear works
    reg_write(1'b1, 8'h01);
    repeat (2) @(negedge clk);
    check(fail_flag === 1'b1, "R8 clear without read ignored", int'(fail_flag), 1);
    reg_read(1'b1, v); check(v == 1, "R7 status read returns 1", v, 1);
    reg_write(1'b1, 8'h01);
    repeat (2) @(negedge clk);
    check(fail_flag === 1'b0, "R8 read then clear", int'(fail_flag), 0);
    reg_read(1'b1, v); check(v == 0, "R8 status reads 0 after clear", v, 0);

    // absent clock: pulse, then hold until recovery
    repeat (4) @(negedge ref_clk);
    bg_high = 0;
    outage(90, 110);
    check(run_s.size() == 2, "R6 pulse then hold", run_s.size(), 2);
    v = run_s.size() > 0 ? run_s[0] : -1;
    check(v >= WIN - 3 && v <= WIN + 5, "R4 trip delay before hold", v, WIN + 2);
    v = run_s.size() > 1 ? run_s[1] : -1;
    check(v >= ABS - 3 && v <= ABS + 5, "R6 hold start", v, ABS + 2);
    e0 = run_s.size() > 1 ? run_s[1] + run_l[1] - 1 : -1;
    check(e0 >= 90 && e0 <= 99, "R6 hold ends after recovery", e0, 94);
    bg_high = 1;
    repeat (20) @(negedge clk);
    check(fail_flag === 1'b1, "R7 flag set by absent clock", int'(fail_flag), 1);

    // chip reset clears enable, keeps flag
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    reg_read(1'b0, v); check(v == 0, "R2 rst clears enable", v, 0);
    check(fail_flag === 1'b1, "R9 flag survives rst", int'(fail_flag), 1);

    // sensed reset line low clears enable, keeps flag
    reg_write(1'b0, 8'h01);
    reg_read(1'b0, v); check(v == 1, "R1 enable set again", v, 1);
    @(negedge clk); rst_pin_n = 0;
    repeat (6) @(negedge clk); rst_pin_n = 1;
    repeat (4) @(negedge clk);
    reg_read(1'b0, v); check(v == 0, "R2 pin low clears enable", v, 0);
    check(fail_flag === 1'b1, "R9 flag survives pin reset", int'(fail_flag), 1);

    // power-on reset clears flag
    bg_high = 0;
    @(negedge clk); por = 1; ref_rst = 1;
    repeat (4) @(negedge ref_clk);
    por = 0; ref_rst = 0;
    repeat (4) @(negedge clk);
    check(fail_flag === 1'b0, "R9 por clears flag", int'(fail_flag), 0);
    check(rst_drive_n === 1'b1, "R10 line released after por", int'(rst_drive_n), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400us;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule